// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a synchronous binary counter built from identical 4-bit stages. Each stage holds its count, can be preset from a parallel data input, and counts up or down in steps of one with wraparound. A stage advances only when both of its active-low count enables are low. One enable goes to every stage in parallel. The other is chained, so the terminal-count output of each stage drives the chained enable of the stage above it. The whole chain then behaves as one wide binary counter, and no gates are needed between stages.

The wrapper joins a parameterised number of stages. It brings out the full count and the active-low terminal-count output of the top stage. All state changes happen on the rising clock edge. The only exception is the active-low asynchronous reset, which clears every stage to zero.

Top module: `ud_cnt_chain`

## Requirements
- R1: While rst_ni is low, count_o is zero. It stays zero after release until the first rising edge that loads or counts.
- R2: When load_ni is low at a rising edge, count_o takes the value of data_i at that edge. This happens whatever the levels of par_en_ni and chain_en_ni.
- R3: When load_ni is high, both par_en_ni and chain_en_ni are low, and up_i is high, a rising edge adds one to count_o. The value wraps from all-ones to zero.
- R4: Under the same conditions with up_i low, a rising edge subtracts one from count_o. The value wraps from zero to all-ones.
- R5: When load_ni is high and either par_en_ni or chain_en_ni is high, count_o keeps its value across the edge.
- R6: term_no is low exactly when chain_en_ni is low and count_o is at its end value for the current direction. The end value is all-ones when up_i is high and zero when up_i is low. par_en_ni has no effect on term_no.
- R7: A carry or borrow out of a lower stage moves the next stage in the same edge. For example, 0x0FF counting up becomes 0x100, and 0x100 counting down becomes 0x0FF.
- R8: Changing up_i between edges never alters count_o. Only the step taken at the next enabled edge changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Parallel preset strobe, active low |
| data_i | input | STAGE_W*STAGES | Preset value |
| up_i | input | 1 | Count direction, 1 = up, 0 = down |
| par_en_ni | input | 1 | Count enable shared by all stages, active low |
| chain_en_ni | input | 1 | Count enable into the lowest stage of the chain, active low |
| count_o | output | STAGE_W*STAGES | Current count |
| term_no | output | 1 | Terminal count of the top stage, active low |

## Verification
The hardest situation to reach from the ports is a carry or borrow that runs through every stage: the full count must sit at all-ones or at zero while both enables are low. Random counting almost never gets there in a 12-bit chain. The stimulus therefore presets values just below the top, at the bottom, and at stage boundaries such as 0x0FF and 0x100, and then counts across them. Around these steps it holds the count at the terminal value with only the parallel enable raised, which shows that term_no still asserts. Between edges it toggles the direction many times, which shows the count does not move.

// File: rtl/ud_cnt_pkg.sv
package ud_cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } cnt_op_e;

  function automatic cnt_op_e decode_op(input logic load_n, input logic par_n,
                                        input logic chain_n, input logic up);
    if (!load_n)               return OP_LOAD;
    else if (!par_n && !chain_n) return up ? OP_INC : OP_DEC;
    else                       return OP_HOLD;
  endfunction
endpackage

// File: rtl/ud_cnt_tc.sv
module ud_cnt_tc #(
  parameter int W = 4
) (
  input  logic [W-1:0] q_i,
  input  logic         up_i,
  input  logic         chain_en_ni,
  output logic         tc_no
);
  logic at_end;
  always_comb begin
    at_end = up_i ? (&q_i) : ~(|q_i);
    tc_no  = ~(~chain_en_ni & at_end);
  end
endmodule

// File: rtl/ud_cnt_stage.sv
module ud_cnt_stage
  import ud_cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_ni,
  input  logic [W-1:0] d_i,
  input  logic         up_i,
  input  logic         par_en_ni,
  input  logic         chain_en_ni,
  output logic [W-1:0] q_o,
  output logic         tc_no
);
  logic [W-1:0] q_q, q_d;
  cnt_op_e      op;

  always_comb begin
    op = decode_op(load_ni, par_en_ni, chain_en_ni, up_i);
    unique case (op)
      OP_LOAD: q_d = d_i;
      OP_INC:  q_d = q_q + W'(1);
      OP_DEC:  q_d = q_q - W'(1);
      default: q_d = q_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  ud_cnt_tc #(.W(W)) i_tc (
    .q_i        (q_q),
    .up_i       (up_i),
    .chain_en_ni(chain_en_ni),
    .tc_no      (tc_no)
  );

  assign q_o = q_q;
endmodule

// File: rtl/ud_cnt_chain.sv
module ud_cnt_chain #(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 3,
  localparam int TOT_W  = STAGE_W * STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [TOT_W-1:0] data_i,
  input  logic             up_i,
  input  logic             par_en_ni,
  input  logic             chain_en_ni,
  output logic [TOT_W-1:0] count_o,
  output logic             term_no
);
  // link[k] is the trickle enable into stage k; link[STAGES] is the chain output
  logic [STAGES:0] link_n;
  assign link_n[0] = chain_en_ni;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    ud_cnt_stage #(.W(STAGE_W)) i_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_ni    (load_ni),
      .d_i        (data_i[k*STAGE_W +: STAGE_W]),
      .up_i       (up_i),
      .par_en_ni  (par_en_ni),
      .chain_en_ni(link_n[k]),
      .q_o        (count_o[k*STAGE_W +: STAGE_W]),
      .tc_no      (link_n[k+1])
    );
  end

  assign term_no = link_n[STAGES];
endmodule

// File: rtl/ud_cnt_chain_chk.sv
module ud_cnt_chain_chk #(
  parameter int TOT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_ni,
  input logic [TOT_W-1:0] data_i,
  input logic             up_i,
  input logic             par_en_ni,
  input logic             chain_en_ni,
  input logic [TOT_W-1:0] count_o,
  input logic             term_no
);
  // R1
  reset_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> count_o == '0);

  // R2
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(data_i));

  // R3
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !par_en_ni && !chain_en_ni && up_i)
      |=> count_o == TOT_W'($past(count_o) + 1'b1));

  // R4
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !par_en_ni && !chain_en_ni && !up_i)
      |=> count_o == TOT_W'($past(count_o) - 1'b1));

  // R5
  hold_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && (par_en_ni || chain_en_ni)) |=> $stable(count_o));

  // R6
  term_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_en_ni |-> term_no);

  // R6
  term_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chain_en_ni && up_i && (&count_o)) |-> !term_no);

  // R6
  term_bottom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chain_en_ni && !up_i && count_o == '0) |-> !term_no);
endmodule

bind ud_cnt_chain ud_cnt_chain_chk #(.TOT_W(TOT_W)) i_ud_cnt_chain_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_ni    (load_ni),
  .data_i     (data_i),
  .up_i       (up_i),
  .par_en_ni  (par_en_ni),
  .chain_en_ni(chain_en_ni),
  .count_o    (count_o),
  .term_no    (term_no)
);

// File: tb/test_ud_cnt_chain.sv
module test_ud_cnt_chain;
  localparam int CLK_PERIOD = 10;
  localparam int STAGE_W = 4;
  localparam int STAGES  = 3;
  localparam int TOT_W   = STAGE_W * STAGES;
  localparam logic [TOT_W-1:0] ALL1 = '1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             load_ni = 1'b1;
  logic [TOT_W-1:0] data_i = '0;
  logic             up_i = 1'b1;
  logic             par_en_ni = 1'b1;
  logic             chain_en_ni = 1'b1;
  logic [TOT_W-1:0] count_o;
  logic             term_no;

  int checks = 0;
  int errors = 0;
  logic [TOT_W-1:0] model = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ud_cnt_chain #(.STAGE_W(STAGE_W), .STAGES(STAGES)) i_ud_cnt_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_ni(load_ni), .data_i(data_i),
    .up_i(up_i), .par_en_ni(par_en_ni), .chain_en_ni(chain_en_ni),
    .count_o(count_o), .term_no(term_no)
  );

  function automatic logic [TOT_W-1:0] next_val(logic [TOT_W-1:0] cur, logic ld_n,
      logic [TOT_W-1:0] d, logic up, logic pe_n, logic ce_n);
    if (!ld_n) return d;
    if (!pe_n && !ce_n) return up ? cur + 1'b1 : cur - 1'b1;
    return cur;
  endfunction

  function automatic logic exp_term(logic [TOT_W-1:0] cur, logic up, logic ce_n);
    return !(!ce_n && (up ? (cur == ALL1) : (cur == '0)));
  endfunction

  task automatic check_cnt(string req);
    checks++;
    if (count_o !== model) begin
      errors++;
      $display("FAIL %s count actual=%h expected=%h", req, count_o, model);
    end
  endtask

  task automatic check_term(string req);
    checks++;
    if (term_no !== exp_term(model, up_i, chain_en_ni)) begin
      errors++;
      $display("FAIL %s term_no actual=%b expected=%b", req, term_no,
               exp_term(model, up_i, chain_en_ni));
    end
  endtask

  // apply at negedge, check term, clock, then check count
  task automatic step(logic ld_n, logic [TOT_W-1:0] d, logic up, logic pe_n,
                      logic ce_n, string req);
    load_ni = ld_n; data_i = d; up_i = up; par_en_ni = pe_n; chain_en_ni = ce_n;
    #1;
    check_term("R6");
    model = next_val(model, ld_n, d, up, pe_n, ce_n);
    @(posedge clk_i);
    @(negedge clk_i);
    check_cnt(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk_i);
    check_cnt("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_cnt("R1");
    step(1, '0, 1, 1, 1, "R1");

    // R2: load with enables inactive and active
    step(0, 12'hA5C, 1, 1, 1, "R2");
    step(0, 12'h3F0, 0, 0, 0, "R2");
    // R3 + R7: up across stage boundaries and wrap
    step(0, 12'h0FE, 1, 1, 1, "R2");
    step(1, '0, 1, 0, 0, "R3");
    step(1, '0, 1, 0, 0, "R7");
    step(0, 12'hFFE, 1, 1, 1, "R2");
    step(1, '0, 1, 0, 0, "R3");
    // R6: term low at all-ones with parallel enable raised
    step(1, '0, 1, 1, 0, "R5");
    step(1, '0, 1, 0, 1, "R5");
    step(1, '0, 1, 0, 0, "R3");
    // R4 + R7: down across boundaries and wrap
    step(0, 12'h101, 0, 1, 1, "R2");
    step(1, '0, 0, 0, 0, "R4");
    step(1, '0, 0, 0, 0, "R7");
    step(0, 12'h001, 0, 1, 1, "R2");
    step(1, '0, 0, 0, 0, "R4");
    step(1, '0, 0, 1, 0, "R5");
    step(1, '0, 0, 0, 0, "R4");

    // R8: direction toggles between edges leave count unchanged
    step(0, 12'h7FF, 1, 1, 1, "R2");
    for (int i = 0; i < 6; i++) begin
      up_i = ~up_i;
      #1;
      check_cnt("R8");
    end
    step(1, '0, 0, 0, 0, "R8");

    for (int i = 0; i < 3000; i++) begin
      logic ld_n, pe_n, ce_n, up;
      logic [TOT_W-1:0] d;
      ld_n = ($urandom_range(0, 9) != 0);
      pe_n = ($urandom_range(0, 6) == 0);
      ce_n = ($urandom_range(0, 6) == 0);
      up   = $urandom_range(0, 1);
      case ($urandom_range(0, 3))
        0: d = ALL1 - TOT_W'($urandom_range(0, 3));
        1: d = TOT_W'($urandom_range(0, 3));
        default: d = TOT_W'($urandom);
      endcase
      step(ld_n, d, up, pe_n, ce_n,
           !ld_n ? "R2" : (pe_n || ce_n) ? "R5" : up ? "R3" : "R4");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule